// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets host software reach the management registers of an Ethernet PHY through two 32-bit host registers: a control register and a data register. They sit on a simple synchronous bus with a combinational read path. The block drives the serial management interface itself. It produces the MDC clock and drives the bidirectional MDIO line as three signals: data out, output enable and data in.

Software first places the value to send in the data register, if it is writing. It then writes the control register with the PHY address, the register index, the direction bit and the busy bit set. Hardware shifts out a complete management frame and clears busy when the frame is done. On a read, the 16-bit value returned by the PHY appears in the data register in the cycle that busy clears. Every host write is dropped while busy is set, so a transaction in flight cannot be disturbed.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both host registers read 32'h00000000, and MDC and the MDIO output enable are 0.
- R2: The control register (bus address 0) holds the PHY address in bits 15:11, the register index in bits 10:6, the write select in bit 1 (1 = write, 0 = read) and busy in bit 0. Bits 31:16 and 5:2 read 0, so writing 32'hFFFFFFFE while idle reads back 32'h0000FFC2.
- R3: The data register (bus address 1) stores bits 15:0 of a host write, and bits 31:16 read 0.
- R4: A control write with bit 0 set while idle starts a transaction. Busy then reads 1 for exactly 64*CLK_DIV system clocks and returns to 0 on its own. A control write with bit 0 clear starts nothing.
- R5: While busy is 1, host writes to either register have no effect. This includes a write in the last busy cycle.
- R6: A frame is sent MSB first in this order: 32 ones, start 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address and the 5-bit register index. A write frame continues with turnaround 10 and the 16 data bits, and drives MDIO for all 64 bits.
- R7: A read frame drives MDIO for its first 46 bits and releases it for the 2 turnaround bits and 16 data bits. The data bits are sampled from MDIO in on rising MDC, MSB first, and are loaded into data bits 15:0 in the cycle busy clears.
- R8: During a transaction, MDC has a period of CLK_DIV system clocks: low for CLK_DIV/2, then high for CLK_DIV/2. There are 64 rising edges per frame. MDIO out changes only together with a falling MDC edge. While idle, MDC stays 0.
- R9: A write transaction leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write (1) or read (0) |
| bus_addr | input | 1 | 0 selects the control register, 1 the data register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational, 0 when not reading |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_in | input | 1 | MDIO value sampled |

## Verification
Completion of a read can fall in the same cycle as a host write. In that cycle, busy clears and the captured PHY value is loaded into the data register. The bench provokes this by timing a data-register write into the last busy cycle, and a control write into it in another run. It judges the result by reading back both registers afterwards: it expects the PHY value, not the written one, and the original control fields with busy clear. Writes issued in the middle of a frame are judged the same way, and also through the recorded frame bits, which must still carry the data that was loaded before the start.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int DIVW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIVW-1:0] RISE_AT = DIVW'(CLK_DIV / 2 - 1);
  localparam logic [DIVW-1:0] FALL_AT = DIVW'(CLK_DIV - 1);

  logic [4:0]      phy_q, reg_q;
  logic            wr_q, busy_q, mdc_q;
  logic [15:0]     data_q, rx_q;
  logic [DIVW-1:0] div_q;
  logic [5:0]      bit_q;
  logic [63:0]     frame;
  logic            host_wr, acc_we, dat_we, rise_tick, fall_tick, last_bit;
  logic            unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[5:2]};

  assign host_wr   = bus_sel & bus_wr & ~busy_q;
  assign acc_we    = host_wr & ~bus_addr;
  assign dat_we    = host_wr & bus_addr;
  assign rise_tick = busy_q && (div_q == RISE_AT);
  assign fall_tick = busy_q && (div_q == FALL_AT);
  assign last_bit  = fall_tick && (bit_q == 6'd63);

  assign frame = {32'hFFFF_FFFF, 2'b01, wr_q ? 2'b01 : 2'b10, phy_q, reg_q,
                  wr_q ? 2'b10 : 2'b00, wr_q ? data_q : 16'h0000};

  assign mdc      = mdc_q;
  assign mdio_out = busy_q & frame[6'd63 - bit_q];
  assign mdio_oe  = busy_q & (wr_q | (bit_q < 6'd46));

  assign bus_rdata = (bus_sel & ~bus_wr)
                   ? (bus_addr ? {16'h0000, data_q}
                               : {16'h0000, phy_q, reg_q, 4'h0, wr_q, busy_q})
                   : 32'h0000_0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q  <= '0;
      reg_q  <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      data_q <= '0;
      rx_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      mdc_q  <= 1'b0;
    end else begin
      if (acc_we) begin
        phy_q  <= bus_wdata[15:11];
        reg_q  <= bus_wdata[10:6];
        wr_q   <= bus_wdata[1];
        busy_q <= bus_wdata[0];
        div_q  <= '0;
        bit_q  <= '0;
        mdc_q  <= 1'b0;
      end
      if (dat_we)
        data_q <= bus_wdata[15:0];
      if (busy_q) begin
        div_q <= fall_tick ? '0 : div_q + 1'b1;
        if (rise_tick) begin
          mdc_q <= 1'b1;
          if (!wr_q && bit_q >= 6'd48)
            rx_q <= {rx_q[14:0], mdio_in};
        end
        if (fall_tick) begin
          mdc_q <= 1'b0;
          bit_q <= bit_q + 1'b1;
        end
        if (last_bit) begin
          busy_q <= 1'b0;
          if (!wr_q)
            data_q <= rx_q;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_addr,
  input logic        start_req,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy_q,
  input logic        wr_q,
  input logic [4:0]  phy_q,
  input logic [4:0]  reg_q,
  input logic [15:0] data_q,
  input logic [15:0] rx_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe)); // R8
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_addr && start_req && !busy_q) |=> busy_q); // R4
  AST_DATA_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q && bus_sel && bus_wr && bus_addr) |=> $stable(data_q)); // R5
  AST_CTRL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_sel && bus_wr && !bus_addr) |=> ($stable(reg_q) && $stable(phy_q) && $stable(wr_q))); // R5
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_out != $past(mdio_out))) |-> $fell(mdc)); // R8
  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy_q); // R8
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && wr_q) |-> $stable(data_q)); // R9
  AST_READ_LOADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !wr_q) |-> (data_q == $past(rx_q))); // R7
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .start_req(bus_wdata[0]), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy_q(busy_q), .wr_q(wr_q),
  .phy_q(phy_q), .reg_q(reg_q), .data_q(data_q), .rx_q(rx_q)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int DIV = 4;
  localparam int BUSY_CYC = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;
  logic [15:0] rd_val = '0;
  int          total = 0, bad = 0;
  int          rise_cnt = 0, gap = 0, hi_len = 0;
  logic        prev_mdc = 1'b0, prev_out = 1'b0, prev_oe = 1'b0;
  logic [63:0] rec_out = '0, rec_oe = '0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? rd_val[63 - rise_cnt] : 1'b1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [4:0] ri, input bit w, input logic [15:0] dv);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, 5'b00001, ri, w ? 2'b10 : 2'b00, w ? dv : 16'h0};
  endfunction

  function automatic logic [63:0] exp_oe(input bit w);
    return w ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
  endfunction

  always @(negedge clk) begin
    gap++;
    if (mdc) hi_len++;
    if (mdc && !prev_mdc) begin
      if (rise_cnt > 0) check(gap == DIV, "R8 mdc period", 64'(gap), 64'(DIV));
      if (rise_cnt < 64) begin
        rec_out[63 - rise_cnt] = mdio_out;
        rec_oe[63 - rise_cnt]  = mdio_oe;
      end
      rise_cnt++;
      gap = 0;
    end
    if (!mdc && prev_mdc) begin
      check(hi_len == DIV / 2, "R8 mdc high time", 64'(hi_len), 64'(DIV / 2));
      hi_len = 0;
    end
    if (prev_oe && mdio_oe && mdio_out != prev_out)
      check(prev_mdc && !mdc, "R8 mdio moved off falling mdc", {63'h0, mdc}, 64'h0);
    prev_mdc = mdc;
    prev_out = mdio_out;
    prev_oe  = mdio_oe;
  end

  task automatic bus_write(input logic a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic xfer(input logic [4:0] ri, input bit w, input logic [15:0] dv,
                      input logic [15:0] rv, input int poke_at);
    logic [31:0] v, ctrl;
    int cnt;
    rd_val = rv;
    if (w) bus_write(1'b1, {16'h0, dv});
    ctrl = {16'h0, 5'b00001, ri, 4'h0, w, 1'b1};
    rise_cnt = 0;
    hi_len = 0;
    rec_out = '0;
    rec_oe = '0;
    bus_write(1'b0, ctrl);
    cnt = 0;
    forever begin
      bus_read(1'b0, v);
      if (!v[0] || cnt > 4 * BUSY_CYC) break;
      cnt++;
      if (cnt == poke_at) begin
        sel = 1'b1; wr = 1'b1; addr = 1'b1; wdata = ~{16'h0, dv ^ rv};
      end
      if (cnt == poke_at + 1) begin
        sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = {16'h0, 5'b10101, ~ri, 4'hF, ~w, 1'b1};
      end
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
    end
    check(cnt == BUSY_CYC, "R4 busy length", 64'(cnt), 64'(BUSY_CYC));
    check(rise_cnt == 64, "R8 mdc rising edges", 64'(rise_cnt), 64'd64);
    check(rec_oe == exp_oe(w), w ? "R6 write drive enable" : "R7 read release", rec_oe, exp_oe(w));
    check((rec_out & exp_oe(w)) == (exp_frame(ri, w, dv) & exp_oe(w)), "R6 frame bits",
          rec_out & exp_oe(w), exp_frame(ri, w, dv) & exp_oe(w));
    bus_read(1'b1, v);
    check(v == {16'h0, w ? dv : rv}, w ? "R9 data kept after write" : "R7 read data loaded",
          64'(v), 64'({16'h0, w ? dv : rv}));
    bus_read(1'b0, v);
    check(v == {ctrl[31:1], 1'b0}, "R5 control fields intact, busy clear", 64'(v), 64'({ctrl[31:1], 1'b0}));
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(1'b0, v);
    check(v == 32'h0, "R1 control reset", 64'(v), 64'h0);
    bus_read(1'b1, v);
    check(v == 32'h0, "R1 data reset", 64'(v), 64'h0);
    check(!mdc && !mdio_oe, "R1 mdc and oe idle", {62'h0, mdc, mdio_oe}, 64'h0);

    bus_write(1'b0, 32'hFFFF_FFFE);
    bus_read(1'b0, v);
    check(v == 32'h0000_FFC2, "R2 control fields and reserved bits", 64'(v), 64'h0000_FFC2);
    repeat (2 * DIV) @(negedge clk);
    check(!mdc && !mdio_oe, "R4 no start without busy bit", {62'h0, mdc, mdio_oe}, 64'h0);
    bus_read(1'b0, v);
    check(v == 32'h0000_FFC2, "R4 busy stays clear", 64'(v), 64'h0000_FFC2);

    bus_write(1'b1, 32'hABCD_1234);
    bus_read(1'b1, v);
    check(v == 32'h0000_1234, "R3 data register width", 64'(v), 64'h0000_1234);

    xfer(5'h1F, 1'b1, 16'hA5C3, 16'h0000, -10);
    xfer(5'h00, 1'b0, 16'h0000, 16'h8001, -10);
    xfer(5'h0B, 1'b1, 16'h1111, 16'h0000, 100);
    xfer(5'h12, 1'b0, 16'h0000, 16'h5A3C, 100);
    xfer(5'h07, 1'b0, 16'h0000, 16'hC0DE, BUSY_CYC);
    xfer(5'h15, 1'b0, 16'h0000, 16'h7E81, BUSY_CYC - 1);
    xfer(5'h19, 1'b1, 16'h0F0F, 16'h0000, BUSY_CYC - 1);

    for (int i = 0; i < 10; i++) begin
      xfer(5'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
           ($urandom % 3 == 0) ? int'($urandom % BUSY_CYC) + 1 : -10);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule